// File: doc/BRIEF.md
# Host Pixel Port with Dimension-Driven Framing

This block connects a host data bus to raw pixel streams in both directions. On the write side, the host pushes bus words that are split into pixel samples and handed on as a valid/ready stream. On the read side, a valid/ready pixel stream is gathered into bus words that the host collects with read strobes. The host bus carries no timing codes or sync lines. Frame boundaries come from a column counter and a row counter on each side, which are compared against the programmed frame width and height.

The bus width can be 8, 16 or 32 bits, and it is chosen at run time. Samples of 8 bits fill one byte. Samples of 10, 12, 14 or 16 bits fill a two-byte container and are aligned to its most significant bit. Bytes travel in big-endian order, so the earliest sample or the high byte always comes first. The configuration is sampled while a side is idle and is held from the first transfer of a frame until that frame's final pixel.

Top module: `host_pixel_port`

## Requirements
- R1: After reset, `po_valid` and `hr_valid` are 0, and `hw_rdy` and `pi_ready` are 1.
- R2: Bus-width code `cfg_bus` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. For 8-bit samples on a 32-bit write word, the samples leave in the order hw_data[31:24], [23:16], [15:8], [7:0].
- R3: Sample-width code `cfg_smp` 0, 1, 2 and 3 selects 8, 10, 12 and 14 bits; 4 to 7 selects 16 bits. A wider sample arrives in a 16-bit container. The container in hw_data[31:16] comes out first. `po_data` is the container shifted right by (16 − width), so container bits below the sample are dropped.
- R4: On an 8- or 16-bit bus, only the low lanes of `hw_data` are used. A 16-bit container carried over two 8-bit beats takes its high byte from the first beat.
- R5: `po_sof` is 1 only on the first pixel of a frame. `po_eof` is 1 only on pixel number `cfg_cols`×`cfg_rows`. The next pixel after that starts a new frame.
- R6: Bytes that remain in a write word after the pixel marked end-of-frame are discarded. The next word starts the next frame.
- R7: On the read side, the first sample goes to the most significant position of the word. A sample is placed as `pi_data` shifted left by (16 − width) in its container. `pi_data` bits at or above the sample width are ignored.
- R8: For an 8- or 16-bit bus, `hr_data` carries the word in its low lanes, and the unused upper lanes read 0.
- R9: A final read word that is only partly filled is padded with zero bytes. `hr_last` is 1 exactly on the word that holds the last byte of a frame.
- R10: Configuration changes made during a frame take effect only from the next frame.
- R11: A pending output is held steady under back-pressure. While `po_valid` is 1 and `po_ready` is 0, `po_data` and the frame markers stay stable and `hw_rdy` is 0. While `hr_valid` is 1 and `hr_stb` is 0, `hr_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | DIM_W | Frame width in pixels (at least 1) |
| cfg_rows | input | DIM_W | Frame height in lines (at least 1) |
| cfg_bus | input | 2 | Bus-width code |
| cfg_smp | input | 3 | Sample-width code |
| hw_stb | input | 1 | Host write strobe |
| hw_data | input | 32 | Host write word |
| hw_rdy | output | 1 | Write strobe accepted this cycle |
| po_valid | output | 1 | Outgoing pixel valid |
| po_ready | input | 1 | Outgoing pixel taken |
| po_data | output | 16 | Outgoing sample, right-aligned |
| po_sof | output | 1 | Outgoing pixel starts a frame |
| po_eof | output | 1 | Outgoing pixel ends a frame |
| pi_valid | input | 1 | Incoming pixel valid |
| pi_ready | output | 1 | Incoming pixel accepted |
| pi_data | input | 16 | Incoming sample, right-aligned |
| hr_stb | input | 1 | Host read strobe |
| hr_valid | output | 1 | Read word available |
| hr_data | output | 32 | Read word |
| hr_last | output | 1 | Read word closes the frame |

## Verification
The hardest case to reach is a configuration change in the middle of a frame. It requires a frame that is partly moved, then new width and bus values, then the rest of the frame. The stimulus writes one word of a six-pixel frame, switches to a two-pixel frame on a 16-bit bus, and finishes the frame with a 32-bit word. It then checks that the following word is split with the new settings. Trailing padding is reached in a similar way. The frame sizes are chosen so that the last pixel falls inside a bus word, which leaves discarded bytes on the write side and zero-filled bytes on the read side.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

   typedef enum logic [1:0] {
      BUS_8  = 2'd0,
      BUS_16 = 2'd1,
      BUS_32 = 2'd2
   } bus_sel_e;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned CONT_W     = 16;

   // bytes moved per bus beat
   function automatic logic [2:0] bus_bytes(input logic [1:0] sel);
      case (sel)
         BUS_8:   return 3'd1;
         BUS_16:  return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // bytes used by one sample container
   function automatic logic [2:0] cont_bytes(input logic [2:0] sel);
      return (sel == 3'd0) ? 3'd1 : 3'd2;
   endfunction

   // significant bits of one sample
   function automatic logic [4:0] smp_bits(input logic [2:0] sel);
      case (sel)
         3'd0:    return 5'd8;
         3'd1:    return 5'd10;
         3'd2:    return 5'd12;
         3'd3:    return 5'd14;
         default: return 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/hpp_frame_ctr.sv
module hpp_frame_ctr #(
   parameter int unsigned DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [DIM_W-1:0] cols,
   input  logic [DIM_W-1:0] rows,
   output logic             at_origin,
   output logic             is_last
);
   localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

   logic [DIM_W-1:0] col_q;
   logic [DIM_W-1:0] row_q;
   logic             col_end;

   assign col_end   = (col_q == cols - ONE);
   assign is_last   = col_end && (row_q == rows - ONE);
   assign at_origin = (col_q == '0) && (row_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (step) begin
         if (is_last) begin
            col_q <= '0;
            row_q <= '0;
         end else if (col_end) begin
            col_q <= '0;
            row_q <= row_q + ONE;
         end else begin
            col_q <= col_q + ONE;
         end
      end
   end
endmodule

// File: rtl/hpp_cfg_hold.sv
module hpp_cfg_hold #(
   parameter int unsigned DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic [DIM_W-1:0] live_cols,
   input  logic [DIM_W-1:0] live_rows,
   input  logic [1:0]       live_bus,
   input  logic [2:0]       live_smp,
   output logic [DIM_W-1:0] eff_cols,
   output logic [DIM_W-1:0] eff_rows,
   output logic [1:0]       eff_bus,
   output logic [2:0]       eff_smp
);
   logic [DIM_W-1:0] cols_q;
   logic [DIM_W-1:0] rows_q;
   logic [1:0]       bus_q;
   logic [2:0]       smp_q;

   // live values pass through while idle; the snapshot is frozen otherwise
   assign eff_cols = idle ? live_cols : cols_q;
   assign eff_rows = idle ? live_rows : rows_q;
   assign eff_bus  = idle ? live_bus  : bus_q;
   assign eff_smp  = idle ? live_smp  : smp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cols_q <= DIM_W'(1);
         rows_q <= DIM_W'(1);
         bus_q  <= 2'd2;
         smp_q  <= 3'd0;
      end else begin
         cols_q <= eff_cols;
         rows_q <= eff_rows;
         bus_q  <= eff_bus;
         smp_q  <= eff_smp;
      end
   end
endmodule

// File: rtl/hpp_unpack.sv
module hpp_unpack
   import hpp_pkg::*;
#(
   parameter int unsigned DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIM_W-1:0] cfg_cols,
   input  logic [DIM_W-1:0] cfg_rows,
   input  logic [1:0]       cfg_bus,
   input  logic [2:0]       cfg_smp,
   input  logic             hw_stb,
   input  logic [31:0]      hw_data,
   output logic             hw_rdy,
   output logic             px_valid,
   input  logic             px_ready,
   output logic [15:0]      px_data,
   output logic             px_sof,
   output logic             px_eof
);
   logic [31:0]      acc_q;
   logic [2:0]       nb_q;
   logic             at_origin, is_last, idle;
   logic [DIM_W-1:0] e_cols, e_rows;
   logic [1:0]       e_bus;
   logic [2:0]       e_smp;
   logic [2:0]       bb, cb;
   logic [4:0]       sw;
   logic [15:0]      c16;
   logic [31:0]      aligned, placed;
   logic             wr_fire, emit;

   assign idle = (nb_q == 3'd0) && at_origin;

   hpp_cfg_hold #(.DIM_W(DIM_W)) i_hold (
      .clk(clk), .rst_n(rst_n), .idle(idle),
      .live_cols(cfg_cols), .live_rows(cfg_rows),
      .live_bus(cfg_bus), .live_smp(cfg_smp),
      .eff_cols(e_cols), .eff_rows(e_rows),
      .eff_bus(e_bus), .eff_smp(e_smp)
   );

   hpp_frame_ctr #(.DIM_W(DIM_W)) i_ctr (
      .clk(clk), .rst_n(rst_n), .step(emit),
      .cols(e_cols), .rows(e_rows),
      .at_origin(at_origin), .is_last(is_last)
   );

   assign bb = bus_bytes(e_bus);
   assign cb = cont_bytes(e_smp);
   assign sw = smp_bits(e_smp);

   assign hw_rdy   = (nb_q < cb);
   assign px_valid = (nb_q >= cb);
   assign wr_fire  = hw_stb && hw_rdy;
   assign emit     = px_valid && px_ready;

   // container sits at the top of the accumulator, MSB aligned
   assign c16     = (cb == 3'd1) ? {acc_q[31:24], 8'h00} : acc_q[31:16];
   assign px_data = c16 >> (5'd16 - sw);
   assign px_sof  = at_origin;
   assign px_eof  = is_last;

   // active low lanes move to the top, then below the bytes already held
   assign aligned = hw_data << {(3'd4 - bb), 3'b000};
   assign placed  = aligned >> {nb_q, 3'b000};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         nb_q  <= '0;
      end else if (wr_fire) begin
         acc_q <= acc_q | placed;
         nb_q  <= nb_q + bb;
      end else if (emit) begin
         if (is_last) begin
            acc_q <= '0;
            nb_q  <= '0;
         end else begin
            acc_q <= acc_q << {cb, 3'b000};
            nb_q  <= nb_q - cb;
         end
      end
   end
endmodule

// File: rtl/hpp_pack.sv
module hpp_pack
   import hpp_pkg::*;
#(
   parameter int unsigned DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIM_W-1:0] cfg_cols,
   input  logic [DIM_W-1:0] cfg_rows,
   input  logic [1:0]       cfg_bus,
   input  logic [2:0]       cfg_smp,
   input  logic             px_valid,
   output logic             px_ready,
   input  logic [15:0]      px_data,
   input  logic             hr_stb,
   output logic             hr_valid,
   output logic [31:0]      hr_data,
   output logic             hr_last
);
   logic [31:0]      acc_q, acc_mid, ins, placed;
   logic [2:0]       nb_q, nb_mid, consume;
   logic             flush_q;
   logic             at_origin, is_last, idle;
   logic [DIM_W-1:0] e_cols, e_rows;
   logic [1:0]       e_bus;
   logic [2:0]       e_smp;
   logic [2:0]       bb, cb;
   logic [4:0]       sw;
   logic [15:0]      c16;
   logic             take, rd_fire;

   assign idle = (nb_q == 3'd0) && at_origin && !flush_q;

   hpp_cfg_hold #(.DIM_W(DIM_W)) i_hold (
      .clk(clk), .rst_n(rst_n), .idle(idle),
      .live_cols(cfg_cols), .live_rows(cfg_rows),
      .live_bus(cfg_bus), .live_smp(cfg_smp),
      .eff_cols(e_cols), .eff_rows(e_rows),
      .eff_bus(e_bus), .eff_smp(e_smp)
   );

   hpp_frame_ctr #(.DIM_W(DIM_W)) i_ctr (
      .clk(clk), .rst_n(rst_n), .step(take),
      .cols(e_cols), .rows(e_rows),
      .at_origin(at_origin), .is_last(is_last)
   );

   assign bb = bus_bytes(e_bus);
   assign cb = cont_bytes(e_smp);
   assign sw = smp_bits(e_smp);

   assign px_ready = !flush_q && ((nb_q + cb) <= 3'd4);
   assign hr_valid = (nb_q >= bb) || (flush_q && (nb_q != 3'd0));
   assign hr_last  = flush_q && (nb_q <= bb);
   assign hr_data  = acc_q >> {(3'd4 - bb), 3'b000};

   assign take    = px_valid && px_ready;
   assign rd_fire = hr_stb && hr_valid;

   // a read drains one word (or what is left of it) before any insertion
   assign consume = !rd_fire ? 3'd0 : ((nb_q < bb) ? nb_q : bb);
   assign nb_mid  = nb_q - consume;
   assign acc_mid = rd_fire ? (acc_q << {bb, 3'b000}) : acc_q;

   assign c16    = px_data << (5'd16 - sw);
   assign ins    = (cb == 3'd1) ? {c16[15:8], 24'h0} : {c16, 16'h0};
   assign placed = ins >> {nb_mid, 3'b000};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         nb_q    <= '0;
         flush_q <= 1'b0;
      end else begin
         acc_q <= take ? (acc_mid | placed) : acc_mid;
         nb_q  <= nb_mid + (take ? cb : 3'd0);
         if (take && is_last)
            flush_q <= 1'b1;
         else if (rd_fire && hr_last)
            flush_q <= 1'b0;
      end
   end
endmodule

// File: rtl/host_pixel_port.sv
module host_pixel_port #(
   parameter int unsigned DIM_W  = 12,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned PIX_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIM_W-1:0] cfg_cols,
   input  logic [DIM_W-1:0] cfg_rows,
   input  logic [1:0]       cfg_bus,
   input  logic [2:0]       cfg_smp,
   input  logic             hw_stb,
   input  logic [BUS_W-1:0] hw_data,
   output logic             hw_rdy,
   output logic             po_valid,
   input  logic             po_ready,
   output logic [PIX_W-1:0] po_data,
   output logic             po_sof,
   output logic             po_eof,
   input  logic             pi_valid,
   output logic             pi_ready,
   input  logic [PIX_W-1:0] pi_data,
   input  logic             hr_stb,
   output logic             hr_valid,
   output logic [BUS_W-1:0] hr_data,
   output logic             hr_last
);
   generate
      if (BUS_W != 32) begin : g_bad_bus
         $error("host_pixel_port: BUS_W must be 32");
      end
      if (PIX_W != 16) begin : g_bad_pix
         $error("host_pixel_port: PIX_W must be 16");
      end
      if (DIM_W < 2 || DIM_W > 16) begin : g_bad_dim
         $error("host_pixel_port: DIM_W must be 2..16");
      end
   endgenerate

   hpp_unpack #(.DIM_W(DIM_W)) i_unpack (
      .clk(clk), .rst_n(rst_n),
      .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .cfg_bus(cfg_bus), .cfg_smp(cfg_smp),
      .hw_stb(hw_stb), .hw_data(hw_data), .hw_rdy(hw_rdy),
      .px_valid(po_valid), .px_ready(po_ready), .px_data(po_data),
      .px_sof(po_sof), .px_eof(po_eof)
   );

   hpp_pack #(.DIM_W(DIM_W)) i_pack (
      .clk(clk), .rst_n(rst_n),
      .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .cfg_bus(cfg_bus), .cfg_smp(cfg_smp),
      .px_valid(pi_valid), .px_ready(pi_ready), .px_data(pi_data),
      .hr_stb(hr_stb), .hr_valid(hr_valid), .hr_data(hr_data),
      .hr_last(hr_last)
   );
endmodule

// File: rtl/host_pixel_port_chk.sv
module host_pixel_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hw_rdy,
   input logic        po_valid,
   input logic        po_ready,
   input logic [15:0] po_data,
   input logic        po_sof,
   input logic        po_eof,
   input logic        hr_stb,
   input logic        hr_valid,
   input logic [31:0] hr_data,
   input logic        hr_last
);
   // R11: a stalled pixel keeps its value and markers and blocks writes
   assert_po_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      po_valid && !po_ready |=> po_valid && !hw_rdy && $stable(po_data)
                                && $stable(po_sof) && $stable(po_eof));

   // R11: an uncollected read word does not change
   assert_hr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hr_valid && !hr_stb |=> hr_valid && $stable(hr_data));

   // R6: nothing remains to emit after the end-of-frame pixel
   assert_eof_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      po_valid && po_ready && po_eof |=> !po_valid);

   // R5: a pixel inside a frame is never followed by a start marker
   assert_sof_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      po_valid && po_ready && !po_eof |=> !(po_valid && po_sof));

   // R9: the word flagged last empties the read side
   assert_last_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hr_valid && hr_stb && hr_last |=> !hr_valid);
endmodule

bind host_pixel_port host_pixel_port_chk i_chk (
   .clk(clk), .rst_n(rst_n), .hw_rdy(hw_rdy),
   .po_valid(po_valid), .po_ready(po_ready), .po_data(po_data),
   .po_sof(po_sof), .po_eof(po_eof),
   .hr_stb(hr_stb), .hr_valid(hr_valid), .hr_data(hr_data),
   .hr_last(hr_last)
);

// File: tb/test_host_pixel_port.sv
module test_host_pixel_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_cols = 12'd1;
   logic [11:0] cfg_rows = 12'd1;
   logic [1:0]  cfg_bus = 2'd2;
   logic [2:0]  cfg_smp = 3'd0;
   logic        hw_stb = 1'b0;
   logic [31:0] hw_data = '0;
   logic        hw_rdy;
   logic        po_valid;
   logic        po_ready = 1'b1;
   logic [15:0] po_data;
   logic        po_sof, po_eof;
   logic        pi_valid = 1'b0;
   logic        pi_ready;
   logic [15:0] pi_data = '0;
   logic        hr_stb = 1'b1;
   logic        hr_valid;
   logic [31:0] hr_data;
   logic        hr_last;

   int checks = 0;
   int errors = 0;

   logic [15:0] cap_d   [64];
   logic        cap_sof [64];
   logic        cap_eof [64];
   int          ncap = 0;
   logic [31:0] rd_d    [64];
   logic        rd_last [64];
   int          nrd = 0;

   always #5 clk = ~clk;

   host_pixel_port i_host_pixel_port (
      .clk(clk), .rst_n(rst_n),
      .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .cfg_bus(cfg_bus), .cfg_smp(cfg_smp),
      .hw_stb(hw_stb), .hw_data(hw_data), .hw_rdy(hw_rdy),
      .po_valid(po_valid), .po_ready(po_ready), .po_data(po_data),
      .po_sof(po_sof), .po_eof(po_eof),
      .pi_valid(pi_valid), .pi_ready(pi_ready), .pi_data(pi_data),
      .hr_stb(hr_stb), .hr_valid(hr_valid), .hr_data(hr_data),
      .hr_last(hr_last)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (po_valid && po_ready && ncap < 64) begin
            cap_d[ncap]   = po_data;
            cap_sof[ncap] = po_sof;
            cap_eof[ncap] = po_eof;
            ncap++;
         end
         if (hr_valid && hr_stb && nrd < 64) begin
            rd_d[nrd]    = hr_data;
            rd_last[nrd] = hr_last;
            nrd++;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int cols, input int rows, input logic [1:0] bus, input logic [2:0] smp);
      @(posedge clk); #1;
      cfg_cols = 12'(cols);
      cfg_rows = 12'(rows);
      cfg_bus  = bus;
      cfg_smp  = smp;
   endtask

   task automatic wr(input logic [31:0] w);
      @(posedge clk); #1;
      hw_stb  = 1'b1;
      hw_data = w;
      do @(negedge clk); while (!hw_rdy);
      @(posedge clk); #1;
      hw_stb = 1'b0;
   endtask

   task automatic push(input logic [15:0] d);
      @(posedge clk); #1;
      pi_valid = 1'b1;
      pi_data  = d;
      do @(negedge clk); while (!pi_ready);
      @(posedge clk); #1;
      pi_valid = 1'b0;
   endtask

   task automatic wait_cap(input int n);
      for (int i = 0; i < 100 && ncap < n; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_rd(input int n);
      for (int i = 0; i < 100 && nrd < n; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 po_valid", 32'(po_valid), 32'd0);
      check("R1 hr_valid", 32'(hr_valid), 32'd0);
      check("R1 hw_rdy",   32'(hw_rdy),   32'd1);
      check("R1 pi_ready", 32'(pi_ready), 32'd1);
   endtask

   task automatic t_bytes32;
      set_cfg(3, 2, 2'd2, 3'd0);
      ncap = 0;
      wr(32'h1122_3344);
      wr(32'h5566_7788);
      wait_cap(6);
      check("R2 count", 32'(ncap), 32'd6);
      check("R2 px0", 32'(cap_d[0]), 32'h11);
      check("R2 px3", 32'(cap_d[3]), 32'h44);
      check("R2 px5", 32'(cap_d[5]), 32'h66);
      check("R5 sof0", 32'(cap_sof[0]), 32'd1);
      check("R5 sof1", 32'(cap_sof[1]), 32'd0);
      check("R5 eof4", 32'(cap_eof[4]), 32'd0);
      check("R5 eof5", 32'(cap_eof[5]), 32'd1);
      ncap = 0;
      wr(32'hA1A2_A3A4);
      wr(32'hB1B2_B3B4);
      wait_cap(6);
      check("R6 next frame px0", 32'(cap_d[0]), 32'hA1);
      check("R6 next frame sof", 32'(cap_sof[0]), 32'd1);
      check("R6 px4", 32'(cap_d[4]), 32'hB1);
      check("R5 eof new frame", 32'(cap_eof[5]), 32'd1);
   endtask

   task automatic t_wide32;
      set_cfg(2, 1, 2'd2, 3'd2);
      ncap = 0;
      wr(32'hABC0_123F);
      wait_cap(2);
      check("R3 count", 32'(ncap), 32'd2);
      check("R3 upper first", 32'(cap_d[0]), 32'h0ABC);
      check("R3 low bits dropped", 32'(cap_d[1]), 32'h0123);
      check("R3 eof", 32'(cap_eof[1]), 32'd1);
   endtask

   task automatic t_narrow8;
      set_cfg(2, 1, 2'd0, 3'd4);
      ncap = 0;
      wr(32'hFFFF_FF12);
      wr(32'h0000_0034);
      wr(32'hAA00_0056);
      wr(32'h0000_0078);
      wait_cap(2);
      check("R4 count", 32'(ncap), 32'd2);
      check("R4 px0", 32'(cap_d[0]), 32'h1234);
      check("R4 px1", 32'(cap_d[1]), 32'h5678);
   endtask

   task automatic t_backpressure;
      set_cfg(4, 1, 2'd2, 3'd0);
      po_ready = 1'b0;
      ncap = 0;
      wr(32'hDEAD_BEEF);
      @(negedge clk);
      check("R11 valid", 32'(po_valid), 32'd1);
      check("R11 data", 32'(po_data), 32'hDE);
      check("R11 hw_rdy low", 32'(hw_rdy), 32'd0);
      repeat (4) @(negedge clk);
      check("R11 still data", 32'(po_data), 32'hDE);
      check("R11 still sof", 32'(po_sof), 32'd1);
      @(posedge clk); #1;
      po_ready = 1'b1;
      wait_cap(4);
      check("R11 px1", 32'(cap_d[1]), 32'hAD);
      check("R11 px3", 32'(cap_d[3]), 32'hEF);
      check("R11 eof", 32'(cap_eof[3]), 32'd1);
   endtask

   task automatic t_midframe;
      set_cfg(6, 1, 2'd2, 3'd0);
      ncap = 0;
      wr(32'h0102_0304);
      wait_cap(4);
      set_cfg(2, 1, 2'd1, 3'd0);
      wr(32'h0506_0000);
      wait_cap(6);
      check("R10 count", 32'(ncap), 32'd6);
      check("R10 old width px5", 32'(cap_d[5]), 32'h06);
      check("R10 old eof", 32'(cap_eof[5]), 32'd1);
      check("R10 no early eof", 32'(cap_eof[1]), 32'd0);
      ncap = 0;
      wr(32'h0000_0708);
      wait_cap(2);
      check("R10 new bus px0", 32'(cap_d[0]), 32'h07);
      check("R10 new sof", 32'(cap_sof[0]), 32'd1);
      check("R10 new eof", 32'(cap_eof[1]), 32'd1);
   endtask

   task automatic t_pack8;
      set_cfg(3, 1, 2'd2, 3'd0);
      nrd = 0;
      push(16'hFF0A);
      push(16'h000B);
      push(16'h120C);
      wait_rd(1);
      check("R7 words", 32'(nrd), 32'd1);
      check("R7 R9 padded word", rd_d[0], 32'h0A0B_0C00);
      check("R9 last", 32'(rd_last[0]), 32'd1);
   endtask

   task automatic t_pack10;
      set_cfg(3, 1, 2'd2, 3'd1);
      nrd = 0;
      push(16'h03FF);
      push(16'hFC01);
      push(16'h0155);
      wait_rd(2);
      check("R7 words", 32'(nrd), 32'd2);
      check("R7 word0", rd_d[0], 32'hFFC0_0040);
      check("R9 not last", 32'(rd_last[0]), 32'd0);
      check("R9 word1 padded", rd_d[1], 32'h5540_0000);
      check("R9 last", 32'(rd_last[1]), 32'd1);
   endtask

   task automatic t_pack_narrow;
      set_cfg(1, 2, 2'd0, 3'd3);
      nrd = 0;
      push(16'h2345);
      push(16'h0001);
      wait_rd(4);
      check("R8 words", 32'(nrd), 32'd4);
      check("R8 byte0", rd_d[0], 32'h0000_008D);
      check("R8 byte1", rd_d[1], 32'h0000_0014);
      check("R8 byte3", rd_d[3], 32'h0000_0004);
      check("R9 last mid", 32'(rd_last[2]), 32'd0);
      check("R9 last end", 32'(rd_last[3]), 32'd1);
      set_cfg(2, 1, 2'd1, 3'd0);
      nrd = 0;
      push(16'h00C3);
      push(16'h003C);
      wait_rd(1);
      check("R8 16-bit lanes", rd_d[0], 32'h0000_C33C);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_bytes32();
      t_wide32();
      t_narrow8();
      t_backpressure();
      t_midframe();
      t_pack8();
      t_pack10();
      t_pack_narrow();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule